// File: doc/BRIEF.md
# Temperature Compensation Update Scheduler

This block decides when the temperature of a crystal oscillator is measured and when its capacitor trim is rewritten. It counts a one-second tick to launch a conversion shortly after power-up and then at a fixed interval. It also accepts conversions requested by software. A start/done handshake drives an external sensor model. When a conversion finishes, the block looks up a capacitance code for the measured temperature in an external table. It adds a signed aging offset to that code, clamps the sum to the trim range, and writes the result to the trim output.

Not every conversion changes the trim. A scheduled conversion reloads the trim only if the temperature differs from the previous reading. A software-requested conversion always reloads it. An aging-offset change alone therefore takes effect only at the next reload. A user request that arrives during a conversion is remembered and served once the current conversion finishes.

Top module: `tcomp_sched`

## Requirements
- R1: While reset is held and after its release, until the first conversion is launched, `trim_o` is 0 and `busy_o` and `conv_start_o` are 0.
- R2: The first conversion is launched on the clock edge that samples the STARTUP_S-th tick after reset, so `conv_start_o` is high in the cycle that follows. Its result always loads the trim.
- R3: Scheduled conversions are launched on the edge that samples every PERIOD_S-th tick counted after the first conversion. User conversions do not move this schedule.
- R4: The loaded trim is the table code (unsigned, TRIM_W bits) plus the two's-complement aging offset. The sum clamps at 0 and at 2^TRIM_W-1 instead of wrapping.
- R5: A scheduled conversion whose temperature equals the previous reading leaves `trim_o` unchanged, even if `aging_i` has changed.
- R6: A scheduled conversion whose temperature differs from the previous reading loads a new trim.
- R7: A one-cycle `user_req_i` pulse while the block is idle launches a conversion, with `conv_start_o` high two cycles after the cycle the pulse was driven. Its result always loads the trim.
- R8: A user request made while a conversion is in progress is held and launched after that conversion completes.
- R9: `conv_start_o` is a single-cycle pulse. `busy_o` is high from that cycle through the cycle after the one in which `conv_done_i` is sampled. `trim_o` changes on the edge after the done edge, together with the fall of `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per second |
| user_req_i | input | 1 | Software conversion request pulse |
| conv_start_o | output | 1 | Conversion launch pulse to the sensor |
| conv_done_i | input | 1 | Sensor reports the result is valid |
| temp_i | input | TEMP_W | Converted temperature |
| lut_addr_o | output | TEMP_W | Table address (latched temperature) |
| lut_data_i | input | TRIM_W | Capacitance code read from the table at `lut_addr_o` |
| aging_i | input | AGE_W | Signed aging offset |
| busy_o | output | 1 | Conversion or trim update in progress |
| trim_o | output | TRIM_W | Capacitor trim code |

## Verification
A tick sampled at an edge that triggers a launch shows up as `conv_start_o` in the cycle after that edge. A user pulse needs one extra cycle to reach the start because it passes through a pending flag. The bench therefore checks the start at the second falling edge after raising the request. For every launch, it also compares the number of ticks the bench itself has counted against the expected schedule, using both the current count and the count one cycle earlier. The sensor model raises done for one cycle. The bench then expects `busy_o` still high at the next falling edge, and the new trim value with `busy_o` low one falling edge after that.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic [1:0] {
    S_WAIT  = 2'd0,
    S_IDLE  = 2'd1,
    S_CONV  = 2'd2,
    S_APPLY = 2'd3
  } tcs_state_e;
endpackage

// File: rtl/tcs_tick_timer.sv
module tcs_tick_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  output logic fire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign fire_o = en_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (fire_o)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  AST_TIMER_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/tcs_trim_sat.sv
module tcs_trim_sat #(
  parameter int TRIM_W = 8,
  parameter int AGE_W  = 8
) (
  input  logic        [TRIM_W-1:0] code_i,
  input  logic signed [AGE_W-1:0]  age_i,
  output logic        [TRIM_W-1:0] trim_o
);
  localparam int SUM_W = ((TRIM_W > AGE_W) ? TRIM_W : AGE_W) + 2;

  logic signed [SUM_W-1:0] code_s, age_s, sum_s, max_s;

  always_comb begin
    code_s = $signed({{(SUM_W-TRIM_W){1'b0}}, code_i});
    age_s  = $signed({{(SUM_W-AGE_W){age_i[AGE_W-1]}}, age_i});
    max_s  = $signed({{(SUM_W-TRIM_W){1'b0}}, {TRIM_W{1'b1}}});
    sum_s  = code_s + age_s;
    if (sum_s[SUM_W-1])    trim_o = '0;
    else if (sum_s > max_s) trim_o = '1;
    else                    trim_o = sum_s[TRIM_W-1:0];
  end
endmodule

// File: rtl/tcs_load_gate.sv
module tcs_load_gate #(
  parameter int TEMP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              user_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              load_o
);
  logic [TEMP_W-1:0] prev_q;
  logic              first_q;

  // first result, user result, or changed reading
  assign load_o = done_i && (first_q || user_i || (temp_i != prev_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      first_q <= 1'b1;
    end else if (done_i) begin
      prev_q  <= temp_i;
      first_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tcomp_sched.sv
module tcomp_sched
  import tcs_pkg::*;
#(
  parameter int TEMP_W    = 8,
  parameter int TRIM_W    = 8,
  parameter int AGE_W     = 8,
  parameter int STARTUP_S = 2,
  parameter int PERIOD_S  = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic                     user_req_i,
  output logic                     conv_start_o,
  input  logic                     conv_done_i,
  input  logic        [TEMP_W-1:0] temp_i,
  output logic        [TEMP_W-1:0] lut_addr_o,
  input  logic        [TRIM_W-1:0] lut_data_i,
  input  logic signed [AGE_W-1:0]  aging_i,
  output logic                     busy_o,
  output logic        [TRIM_W-1:0] trim_o
);
  tcs_state_e        state_q;
  logic              start_q, user_pend_q, per_pend_q, cur_user_q, do_load_q;
  logic [TEMP_W-1:0] temp_q;
  logic [TRIM_W-1:0] trim_q, trim_new;
  logic              su_fire, per_fire, done_ok, load_now;
  logic              start_user, start_per;

  tcs_tick_timer #(.LIMIT(STARTUP_S)) u_startup (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (state_q == S_WAIT),
    .tick_i(tick_i), .fire_o (su_fire)
  );

  tcs_tick_timer #(.LIMIT(PERIOD_S)) u_period (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (state_q != S_WAIT),
    .tick_i(tick_i), .fire_o (per_fire)
  );

  assign done_ok = conv_done_i && (state_q == S_CONV);

  tcs_load_gate #(.TEMP_W(TEMP_W)) u_gate (
    .clk_i (clk_i), .rst_ni (rst_ni), .done_i (done_ok),
    .user_i(cur_user_q), .temp_i (temp_i), .load_o (load_now)
  );

  tcs_trim_sat #(.TRIM_W(TRIM_W), .AGE_W(AGE_W)) u_sat (
    .code_i(lut_data_i), .age_i(aging_i), .trim_o(trim_new)
  );

  // user requests take priority over a scheduled one
  assign start_user = (state_q == S_IDLE) && user_pend_q;
  assign start_per  = (state_q == S_IDLE) && !user_pend_q && (per_pend_q || per_fire);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_WAIT;
      start_q     <= 1'b0;
      user_pend_q <= 1'b0;
      per_pend_q  <= 1'b0;
      cur_user_q  <= 1'b0;
      do_load_q   <= 1'b0;
      temp_q      <= '0;
      trim_q      <= '0;
    end else begin
      start_q     <= 1'b0;
      user_pend_q <= user_req_i || (user_pend_q && !start_user);
      per_pend_q  <= (per_pend_q || per_fire) && !start_per;
      unique case (state_q)
        S_WAIT: if (su_fire) begin
          state_q    <= S_CONV;
          start_q    <= 1'b1;
          cur_user_q <= 1'b0;
        end
        S_IDLE: if (start_user || start_per) begin
          state_q    <= S_CONV;
          start_q    <= 1'b1;
          cur_user_q <= start_user;
        end
        S_CONV: if (done_ok) begin
          state_q   <= S_APPLY;
          temp_q    <= temp_i;
          do_load_q <= load_now;
        end
        S_APPLY: begin
          if (do_load_q) trim_q <= trim_new;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign conv_start_o = start_q;
  assign busy_o       = (state_q == S_CONV) || (state_q == S_APPLY);
  assign lut_addr_o   = temp_q;
  assign trim_o       = trim_q;

  AST_WAIT_TRIM_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT) |=> $stable(trim_o)); // R1
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o); // R9
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> busy_o); // R9
  AST_TRIM_ONLY_APPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_APPLY) |=> $stable(trim_o)); // R5
  AST_USER_SERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && user_pend_q) |=> conv_start_o); // R7
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && user_req_i) |=> user_pend_q); // R8
endmodule

// File: tb/tcomp_sched_test.sv
module tcomp_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_CYC   = 8;
  localparam int STARTUP_S  = 2;
  localparam int PERIOD_S   = 64;

  logic              clk = 0, rst_n = 0, tick = 0, user_req = 0, conv_done = 0;
  logic        [7:0] temp = 0, lut_addr, lut_data, trim;
  logic signed [7:0] aging = 0;
  logic              conv_start, busy;
  int                checks = 0, errors = 0, tick_cnt = 0, cyc = 0;
  int                seen_ticks, seen_prev, exp_trim, prev_temp;
  bit                done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign lut_data = lut_addr ^ 8'h33;

  tcomp_sched #(.STARTUP_S(STARTUP_S), .PERIOD_S(PERIOD_S)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .user_req_i(user_req),
    .conv_start_o(conv_start), .conv_done_i(conv_done), .temp_i(temp),
    .lut_addr_o(lut_addr), .lut_data_i(lut_data), .aging_i(aging),
    .busy_o(busy), .trim_o(trim)
  );

  always @(posedge clk) if (rst_n && tick) tick_cnt <= tick_cnt + 1;
  always @(negedge clk) if (rst_n) begin
    cyc  <= cyc + 1;
    tick <= ((cyc % TICK_CYC) == TICK_CYC - 1);
  end

  function automatic int sat_exp(int t, int a);
    int s = (t ^ 'h33) + a;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic wait_start(input string req, input int limit);
    int p = tick_cnt;
    bit ok = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (conv_start) begin
        ok = 1; seen_ticks = tick_cnt; seen_prev = p;
        break;
      end
      p = tick_cnt;
    end
    chk({req, " conversion launched"}, int'(ok), 1);
  endtask

  // called at the negedge where conv_start is seen
  task automatic respond(input int t, input int len, input bit req_mid);
    for (int i = 0; i < len; i++) begin
      chk("R9 busy during conversion", int'(busy), 1);
      if (i == 0) chk("R9 start single pulse", int'(conv_start), 1);
      if (i == 1) chk("R9 start single pulse", int'(conv_start), 0);
      user_req = req_mid && (i == 0);
      @(negedge clk);
      user_req = 0;
    end
    conv_done = 1; temp = 8'(t);
    @(negedge clk);
    conv_done = 0;
    chk("R9 busy in update cycle", int'(busy), 1);
    @(negedge clk);
    chk("R9 busy drops after update", int'(busy), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int t, a;
    void'($urandom(32'd2024));
    aging = 8'sd5;
    repeat (3) @(negedge clk);
    chk("R1 reset trim", int'(trim), 0);
    chk("R1 reset busy", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle trim", int'(trim), 0);
    chk("R1 idle start", int'(conv_start), 0);

    // R2 power-up conversion
    wait_start("R2", 200);
    chk("R2 startup tick count", seen_ticks, STARTUP_S);
    chk("R2 launch on the tick edge", seen_prev, STARTUP_S - 1);
    chk("R1 trim before first load", int'(trim), 0);
    respond(100, 4, 0);
    prev_temp = 100; exp_trim = sat_exp(100, 5);
    chk("R2 first result loads", int'(trim), exp_trim);

    // R7/R4 user conversions: directed then random
    for (int i = 0; i < 10; i++) begin
      if (i == 0)      begin t = 100;  a = -7;  end
      else if (i == 1) begin t = 'hCC; a = 20;  end
      else if (i == 2) begin t = 'h33; a = -20; end
      else begin
        t = ($urandom % 4 == 0) ? prev_temp : int'($urandom % 256);
        a = int'($urandom % 61) - 30;
      end
      aging = 8'(a);
      user_req = 1;
      @(negedge clk); user_req = 0;
      @(negedge clk);
      chk("R7 start two cycles after request", int'(conv_start), 1);
      respond(t, 1 + int'($urandom % 6), 0);
      exp_trim = sat_exp(t, a); prev_temp = t;
      if (i == 1 || i == 2) chk("R4 saturated trim", int'(trim), exp_trim);
      else chk("R7 user result loads", int'(trim), exp_trim);
    end

    // R3/R5 scheduled, same temperature
    aging = 8'sd9;
    wait_start("R3", 2000);
    chk("R3 first periodic tick", seen_ticks, STARTUP_S + PERIOD_S);
    chk("R3 launch on tick edge", seen_prev, STARTUP_S + PERIOD_S - 1);
    respond(prev_temp, 3, 0);
    chk("R5 same temperature keeps trim", int'(trim), exp_trim);

    // R6 scheduled, new temperature, R8 user request held while busy
    aging = -8'sd3;
    wait_start("R3", 2000);
    chk("R3 second periodic tick", seen_ticks, STARTUP_S + 2*PERIOD_S);
    t = (prev_temp + 1) % 256;
    respond(t, 5, 1);
    exp_trim = sat_exp(t, -3); prev_temp = t;
    chk("R6 new temperature loads", int'(trim), exp_trim);
    aging = 8'sd12;
    wait_start("R8", 4);
    respond(prev_temp, 2, 0);
    exp_trim = sat_exp(prev_temp, 12);
    chk("R8 held user request loads", int'(trim), exp_trim);
    finish_run();
  end
endmodule